// File: doc/BRIEF.md
# Programmable Reed-Solomon Stream Encoder

This block turns a stream of data symbols over GF(2^m) into systematic Reed-Solomon codewords. The symbol width m is set at elaboration. The field reduction polynomial, the codeword length n, the number of parity symbols R and the exponent B of the first generator root are loaded at run time through a configuration strobe. Each new setting makes the block rebuild its generator polynomial g(x) = (x + α^B)(x + α^(B+1))…(x + α^(B+R−1)) inside the block. While that rebuild runs, the block reports itself busy.

Once the rebuild is done, a block of k = n − R data symbols flows through unchanged on a valid/ready stream. The first symbol of a block is marked with a start flag. At the same time a feedback shift register divides the data by g(x). After the last data symbol, the R remainder symbols are emitted, highest degree first, and the final one carries an end flag. The codeword can correct up to R/2 symbol errors. The extra latency of a block equals the R parity cycles that follow its data.

Top module: `rs_stream_enc`

## Requirements
- R1: Within a block, the first k = n − R output symbols equal the accepted input symbols, in order and unchanged. `out_sob` is high on the first of them only.
- R2: Exactly R parity symbols follow the data. They equal the remainder of d(x)·x^R divided by g(x), sent from the x^(R−1) coefficient down to x^0. `out_eob` is high on the last parity symbol only.
- R3: `cfg_poly` bit i is the coefficient of x^i of the reduction polynomial, and the x^m term is implied. The generator roots are α^B … α^(B+R−1), with α the class of x. Every output codeword evaluates to zero at each of these roots.
- R4: A configuration is rejected when R = 0, when R > R_MAX, or when R ≥ n. A rejection sets `cfg_err` and keeps the previous setting in force. An accepted configuration clears `cfg_err`.
- R5: After reset, or after an accepted configuration, `busy` is high for exactly B + R + 2 cycles. While `busy` is high, `in_ready` and `out_valid` are low.
- R6: In idle, an input symbol without `in_sob` is consumed (`in_ready` high) and produces no output.
- R7: An `in_sob` on a symbol after the first of a block is treated as ordinary data.
- R8: A configuration strobe that arrives while a block is in progress has no effect: `cfg_err`, `busy` and the current code stay unchanged.
- R9: When a configuration strobe and a start-of-block symbol arrive in the same idle cycle, the configuration is taken and `in_ready` is low. The held symbol then starts a block encoded with the new setting.
- R10: While `out_ready` is low, no input is accepted, and a pending parity symbol holds its value with `out_valid` high.
- R11: Right after reset, `busy` is high, `out_valid` and `cfg_err` are low, and the default code given by the parameters is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration strobe, taken only in idle |
| cfg_poly | input | SYM_W | Reduction polynomial below x^m |
| cfg_len | input | SYM_W | Codeword length n |
| cfg_nchk | input | clog2(R_MAX+1) | Parity symbol count R |
| cfg_root | input | SYM_W | First root exponent B |
| cfg_err | output | 1 | Last configuration was rejected |
| busy | output | 1 | Generator rebuild in progress |
| in_valid | input | 1 | Input symbol valid |
| in_ready | output | 1 | Input symbol accepted |
| in_sob | input | 1 | Input symbol starts a block |
| in_data | input | SYM_W | Input data symbol |
| out_valid | output | 1 | Output symbol valid |
| out_ready | input | 1 | Downstream accepts output |
| out_sob | output | 1 | First symbol of a codeword |
| out_eob | output | 1 | Last symbol of a codeword |
| out_data | output | SYM_W | Output symbol |

## Verification
The two events that can meet in one cycle are a configuration strobe and a start-of-block symbol, both offered while idle. The bench drives them on the same edge. It confirms that `in_ready` is low in that cycle, keeps the symbol offered through the rebuild, and then checks the codeword it yields against a division model and a root evaluation for the new code. A second case raises the strobe in the middle of a block, and the codeword must still match the old code.

// File: rtl/rse_pkg.sv
package rse_pkg;

    // Control phases of the encoder
    typedef enum logic [2:0] {
        ST_POWER  = 3'd0,   // raising alpha to the first root exponent
        ST_EXPAND = 3'd1,   // multiplying in one generator factor per cycle
        ST_IDLE   = 3'd2,   // waiting for a start-of-block symbol
        ST_DATA   = 3'd3,   // passing data symbols through
        ST_CHECK  = 3'd4    // emitting parity symbols
    } rse_state_e;

endpackage

// File: rtl/rse_gfmul.sv
// Combinational GF(2^W) multiplier with a run-time reduction polynomial.
module rse_gfmul #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] poly,
    output logic [W-1:0] p
);
    logic [W-1:0] acc;

    always_comb begin
        acc = '0;
        for (int i = W - 1; i >= 0; i--) begin
            acc = {acc[W-2:0], 1'b0} ^ (acc[W-1] ? poly : '0) ^ (b[i] ? a : '0);
        end
        p = acc;
    end
endmodule

// File: rtl/rse_genexp.sv
// Generator polynomial builder. Coefficients are kept aligned so the implied
// leading one sits at index R_MAX; coefficient of x^j lies at R_MAX-R+j.
module rse_genexp #(
    parameter int W     = 8,
    parameter int R_MAX = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              poly,
    input  logic                      init,
    input  logic                      pow_step,
    input  logic                      fac_step,
    output logic [R_MAX-1:0][W-1:0]   coef
);
    typedef struct packed {
        logic [W-1:0]             root;
        logic [R_MAX-1:0][W-1:0]  c;
    } gx_t;

    localparam gx_t GX_RST = '{root: W'(1), c: '0};

    gx_t q, d;
    logic [R_MAX-1:0][W-1:0] prod;
    logic [W-1:0] root_x;

    // root times alpha
    assign root_x = {q.root[W-2:0], 1'b0} ^ (q.root[W-1] ? poly : '0);

    generate
        for (genvar gi = 0; gi < R_MAX; gi++) begin : g_fac
            if (gi == R_MAX - 1) begin : g_top
                assign prod[gi] = q.root;          // root times implied one
            end else begin : g_mid
                rse_gfmul #(.W(W)) u_mul (
                    .a   (q.root),
                    .b   (q.c[gi+1]),
                    .poly(poly),
                    .p   (prod[gi])
                );
            end
        end
    endgenerate

    always_comb begin
        d = q;
        if (init) begin
            d = GX_RST;
        end else if (pow_step) begin
            d.root = root_x;
        end else if (fac_step) begin
            for (int i = 0; i < R_MAX; i++) begin
                d.c[i] = q.c[i] ^ prod[i];
            end
            d.root = root_x;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= GX_RST;
        else        q <= d;
    end

    assign coef = q.c;
endmodule

// File: rtl/rse_remreg.sv
// Remainder register. Top stage is fixed at R_MAX-1; stages below R_MAX-R
// see zero coefficients and stay zero.
module rse_remreg #(
    parameter int W     = 8,
    parameter int R_MAX = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              poly,
    input  logic [R_MAX-1:0][W-1:0]   coef,
    input  logic                      en,
    input  logic                      absorb,
    input  logic [W-1:0]              din,
    output logic [W-1:0]              top
);
    typedef struct packed {
        logic [R_MAX-1:0][W-1:0] p;
    } rr_t;

    rr_t q, d;
    logic [W-1:0] fb;
    logic [R_MAX-1:0][W-1:0] prod;

    assign fb = absorb ? (din ^ q.p[R_MAX-1]) : '0;

    generate
        for (genvar gi = 0; gi < R_MAX; gi++) begin : g_tap
            rse_gfmul #(.W(W)) u_mul (
                .a   (fb),
                .b   (coef[gi]),
                .poly(poly),
                .p   (prod[gi])
            );
        end
    endgenerate

    always_comb begin
        d = q;
        if (en) begin
            d.p[0] = prod[0];
            for (int i = 1; i < R_MAX; i++) begin
                d.p[i] = q.p[i-1] ^ prod[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign top = q.p[R_MAX-1];
endmodule

// File: rtl/rs_stream_enc.sv
module rs_stream_enc
    import rse_pkg::*;
#(
    parameter int SYM_W    = 8,
    parameter int R_MAX    = 32,
    parameter int DEF_POLY = 29,
    parameter int DEF_LEN  = 255,
    parameter int DEF_NCHK = 16,
    parameter int DEF_ROOT = 0,
    localparam int RW = $clog2(R_MAX + 1),
    localparam int CW = (SYM_W > RW) ? SYM_W : RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [SYM_W-1:0]  cfg_poly,
    input  logic [SYM_W-1:0]  cfg_len,
    input  logic [RW-1:0]     cfg_nchk,
    input  logic [SYM_W-1:0]  cfg_root,
    output logic              cfg_err,
    output logic              busy,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sob,
    input  logic [SYM_W-1:0]  in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_sob,
    output logic              out_eob,
    output logic [SYM_W-1:0]  out_data
);
    typedef struct packed {
        rse_state_e        st;
        logic [SYM_W-1:0]  poly;
        logic [SYM_W-1:0]  len;
        logic [RW-1:0]     nchk;
        logic [CW-1:0]     cnt;
        logic [SYM_W-1:0]  pos;
        logic              err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:   ST_POWER,
        poly: SYM_W'(DEF_POLY),
        len:  SYM_W'(DEF_LEN),
        nchk: RW'(DEF_NCHK),
        cnt:  CW'(DEF_ROOT),
        pos:  '0,
        err:  1'b0
    };

    ctl_t q, d;
    rse_state_e st_q;
    logic [SYM_W-1:0] k_len;
    logic cfg_bad;
    logic gx_init, gx_pow, gx_fac;
    logic rr_en, rr_abs;
    logic [R_MAX-1:0][SYM_W-1:0] coef;
    logic [SYM_W-1:0] rr_top;

    assign st_q  = q.st;
    assign k_len = q.len - SYM_W'(q.nchk);
    assign cfg_bad = (cfg_nchk == '0) || (cfg_nchk > RW'(R_MAX))
                   || (CW'(cfg_nchk) >= CW'(cfg_len));

    rse_genexp #(.W(SYM_W), .R_MAX(R_MAX)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .poly    (q.poly),
        .init    (gx_init),
        .pow_step(gx_pow),
        .fac_step(gx_fac),
        .coef    (coef)
    );

    rse_remreg #(.W(SYM_W), .R_MAX(R_MAX)) u_rem (
        .clk   (clk),
        .rst_n (rst_n),
        .poly  (q.poly),
        .coef  (coef),
        .en    (rr_en),
        .absorb(rr_abs),
        .din   (in_data),
        .top   (rr_top)
    );

    always_comb begin
        d         = q;
        gx_init   = 1'b0;
        gx_pow    = 1'b0;
        gx_fac    = 1'b0;
        rr_en     = 1'b0;
        rr_abs    = 1'b0;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_sob   = 1'b0;
        out_eob   = 1'b0;
        out_data  = in_data;
        case (st_q)
            ST_POWER: begin
                if (q.cnt == '0) begin
                    d.st  = ST_EXPAND;
                    d.cnt = CW'(q.nchk);
                end else begin
                    gx_pow = 1'b1;
                    d.cnt  = q.cnt - CW'(1);
                end
            end
            ST_EXPAND: begin
                if (q.cnt == '0) begin
                    d.st = ST_IDLE;
                end else begin
                    gx_fac = 1'b1;
                    d.cnt  = q.cnt - CW'(1);
                end
            end
            ST_IDLE: begin
                if (cfg_valid) begin
                    if (cfg_bad) begin
                        d.err = 1'b1;
                    end else begin
                        d.err   = 1'b0;
                        d.poly  = cfg_poly;
                        d.len   = cfg_len;
                        d.nchk  = cfg_nchk;
                        d.cnt   = CW'(cfg_root);
                        d.st    = ST_POWER;
                        gx_init = 1'b1;
                    end
                end else begin
                    in_ready  = !in_sob || out_ready;
                    out_valid = in_valid && in_sob;
                    out_sob   = out_valid;
                    if (in_valid && in_sob && out_ready) begin
                        rr_en  = 1'b1;
                        rr_abs = 1'b1;
                        d.pos  = SYM_W'(1);
                        d.cnt  = '0;
                        d.st   = (k_len == SYM_W'(1)) ? ST_CHECK : ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                in_ready  = out_ready;
                out_valid = in_valid;
                if (in_valid && out_ready) begin
                    rr_en  = 1'b1;
                    rr_abs = 1'b1;
                    d.pos  = q.pos + SYM_W'(1);
                    if (q.pos == k_len - SYM_W'(1)) begin
                        d.st  = ST_CHECK;
                        d.cnt = '0;
                    end
                end
            end
            ST_CHECK: begin
                out_valid = 1'b1;
                out_data  = rr_top;
                out_eob   = (q.cnt == CW'(q.nchk) - CW'(1));
                if (out_ready) begin
                    rr_en = 1'b1;
                    d.cnt = q.cnt + CW'(1);
                    if (out_eob) d.st = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign busy    = (st_q == ST_POWER) || (st_q == ST_EXPAND);
    assign cfg_err = q.err;
endmodule

// File: rtl/rse_chk.sv
module rse_chk
    import rse_pkg::*;
#(
    parameter int SYM_W = 8,
    parameter int R_MAX = 32,
    localparam int RW = $clog2(R_MAX + 1),
    localparam int CW = (SYM_W > RW) ? SYM_W : RW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_valid,
    input logic [SYM_W-1:0]  cfg_len,
    input logic [RW-1:0]     cfg_nchk,
    input logic              cfg_err,
    input logic              busy,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [SYM_W-1:0]  out_data,
    input logic              out_eob,
    input rse_state_e        st
);
    logic req_bad;
    assign req_bad = (cfg_nchk == '0) || (int'(cfg_nchk) > R_MAX)
                   || (int'(cfg_nchk) >= int'(cfg_len));

    a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!in_ready && !out_valid));

    a_r4_reject_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cfg_valid && req_bad) |=> (cfg_err && !busy));

    a_r4_accept_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cfg_valid && !req_bad) |=> (!cfg_err && busy));

    a_r10_parity_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r2_eob_ends_block: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_eob) |=> (st == ST_IDLE));

    a_r8_cfg_midblock: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_DATA || st == ST_CHECK) && cfg_valid) |=> ($stable(cfg_err) && !busy));

    a_r9_cfg_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cfg_valid) |-> (!in_ready && !out_valid));
endmodule

bind rs_stream_enc rse_chk #(.SYM_W(SYM_W), .R_MAX(R_MAX)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_valid(cfg_valid),
    .cfg_len  (cfg_len),
    .cfg_nchk (cfg_nchk),
    .cfg_err  (cfg_err),
    .busy     (busy),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .out_eob  (out_eob),
    .st       (st_q)
);

// File: tb/sim_rs_stream_enc.sv
module sim_rs_stream_enc;
    localparam int CLK_NS = 10;
    localparam int BW     = 4;
    localparam int RM     = 6;
    localparam int RWB    = $clog2(RM + 1);
    localparam int FSZ    = 1 << BW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_valid = 1'b0;
    logic [BW-1:0] cfg_poly = '0;
    logic [BW-1:0] cfg_len = '0;
    logic [RWB-1:0] cfg_nchk = '0;
    logic [BW-1:0] cfg_root = '0;
    logic cfg_err, busy, in_ready, out_valid, out_sob, out_eob;
    logic in_valid = 1'b0;
    logic in_sob = 1'b0;
    logic [BW-1:0] in_data = '0;
    logic out_ready = 1'b0;
    logic [BW-1:0] out_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int cur_poly = 3, cur_n = 15, cur_r = 4, cur_b = 1;
    int dat [32];
    int obuf [40];
    bit osob [40];
    bit oeob [40];

    always #(CLK_NS/2) clk = ~clk;

    rs_stream_enc #(
        .SYM_W(BW), .R_MAX(RM), .DEF_POLY(3), .DEF_LEN(15),
        .DEF_NCHK(4), .DEF_ROOT(1)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_poly(cfg_poly),
        .cfg_len(cfg_len), .cfg_nchk(cfg_nchk), .cfg_root(cfg_root),
        .cfg_err(cfg_err), .busy(busy), .in_valid(in_valid), .in_ready(in_ready),
        .in_sob(in_sob), .in_data(in_data), .out_valid(out_valid),
        .out_ready(out_ready), .out_sob(out_sob), .out_eob(out_eob),
        .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    function automatic int gmul(input int a, input int b, input int poly);
        int acc = 0;
        for (int i = BW - 1; i >= 0; i--) begin
            acc = acc << 1;
            if ((acc & FSZ) != 0) acc = acc ^ (FSZ | poly);
            if (((b >> i) & 1) != 0) acc = acc ^ a;
        end
        return acc & (FSZ - 1);
    endfunction

    function automatic int apow(input int e, input int poly);
        int v = 1;
        for (int i = 0; i < e % (FSZ - 1); i++) v = gmul(v, 2, poly);
        return v;
    endfunction

    task automatic fill(input int seed);
        for (int i = 0; i < 32; i++) dat[i] = (i * 7 + seed * 3 + 5) & (FSZ - 1);
    endtask

    task automatic do_cfg(input int p, input int n, input int r, input int b,
                          input bit ok_exp, input string req);
        int cnt = 0;
        @(negedge clk);
        cfg_valid = 1'b1; cfg_poly = BW'(p); cfg_len = BW'(n);
        cfg_nchk = RWB'(r); cfg_root = BW'(b);
        @(negedge clk);
        cfg_valid = 1'b0;
        while (busy && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
        if (ok_exp) begin
            chk(cnt == b + r + 2, "R5", "busy cycles after config", cnt, b + r + 2);
            chk(cfg_err == 1'b0, req, "cfg_err after accepted config", int'(cfg_err), 0);
            cur_poly = p; cur_n = n; cur_r = r; cur_b = b;
        end else begin
            chk(cnt == 0 && cfg_err == 1'b1, req, "rejected config flag (err*10+busycycles)",
                int'(cfg_err) * 10 + cnt, 10);
        end
    endtask

    task automatic run_block(input bit stall, input bit extra_sob, input bit mid_cfg,
                             input string req);
        int k = cur_n - cur_r;
        int sent = 0, got = 0, cyc = 0, viol = 0;
        bit done = 0;
        int g [8];
        int cw [40];
        int fr = 0, dm = 0, pm = 0, sz = 0;
        while (!done && cyc < 500) begin
            @(negedge clk);
            in_valid  = (sent < k);
            in_data   = BW'(dat[sent]);
            in_sob    = (sent == 0) || (extra_sob && sent == 2);
            out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            cfg_valid = mid_cfg && (sent == 1);
            cfg_poly = BW'(9); cfg_len = BW'(9); cfg_nchk = RWB'(2); cfg_root = '0;
            #1;
            if (in_ready && !out_ready) viol++;
            if (in_valid && in_ready) sent++;
            if (out_valid && out_ready && got < 40) begin
                obuf[got] = int'(out_data);
                osob[got] = out_sob;
                oeob[got] = out_eob;
                got++;
                if (out_eob) done = 1;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sob = 1'b0; cfg_valid = 1'b0;
        // reference generator and division
        for (int i = 0; i < 8; i++) g[i] = 0;
        g[0] = 1;
        for (int j = 0; j < cur_r; j++) begin
            int rt = apow(cur_b + j, cur_poly);
            for (int i = j + 1; i >= 0; i--)
                g[i] = ((i > 0) ? g[i-1] : 0) ^ gmul(rt, g[i], cur_poly);
        end
        for (int i = 0; i < 40; i++) cw[i] = (i < k) ? dat[i] : 0;
        for (int i = 0; i < k; i++) begin
            int c = cw[i];
            for (int j = 1; j <= cur_r; j++) cw[i+j] = cw[i+j] ^ gmul(c, g[cur_r-j], cur_poly);
        end
        chk(got == cur_n, req, "codeword length", got, cur_n);
        for (int i = 0; i < got; i++) begin
            if (osob[i] != (i == 0)) fr++;
            if (oeob[i] != (i == cur_n - 1)) fr++;
            if (i < k && obuf[i] != dat[i]) dm++;
            if (i >= k && i < cur_n && obuf[i] != cw[i]) pm++;
        end
        chk(fr == 0, "R1/R2", "sob/eob misplacements", fr, 0);
        chk(dm == 0, "R1", "data symbol mismatches", dm, 0);
        chk(pm == 0, "R2", "parity symbol mismatches", pm, 0);
        for (int j = cur_b; j < cur_b + cur_r; j++) begin
            int x = apow(j, cur_poly);
            int s = 0;
            for (int i = 0; i < got; i++) s = gmul(s, x, cur_poly) ^ obuf[i];
            if (s != 0) sz++;
        end
        chk(sz == 0, "R3", "nonzero syndromes", sz, 0);
        chk(viol == 0, "R10", "input accepted with out_ready low", viol, 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                bad++; total++;
                $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 150000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(busy == 1'b1, "R11", "busy during reset", int'(busy), 1);
        chk(out_valid == 1'b0 && cfg_err == 1'b0, "R11", "out_valid/cfg_err at reset",
            int'(out_valid) * 2 + int'(cfg_err), 0);
        rst_n = 1'b1;
        cnt = 0;
        while (busy && cnt < 200) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 1 + 4 + 2, "R5", "busy cycles after reset", cnt, 7);
        fill(1);
        run_block(1'b0, 1'b0, 1'b0, "R11");

        // R6: stray symbol without start flag is dropped
        @(negedge clk);
        in_valid = 1'b1; in_sob = 1'b0; in_data = 4'hA; out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1 && out_valid == 1'b0, "R6", "stray symbol consumed silently",
            int'(in_ready) * 2 + int'(out_valid), 2);
        fill(2);
        run_block(1'b1, 1'b0, 1'b0, "R6");

        // R7: start flag inside block is plain data
        fill(3);
        run_block(1'b0, 1'b1, 1'b0, "R7");

        // sweep of polynomials, parity counts, root offsets and lengths
        for (int pi = 0; pi < 2; pi++) begin
            for (int r = 1; r <= RM; r++) begin
                for (int bi = 0; bi < 3; bi++) begin
                    int b = (bi == 0) ? 0 : (bi == 1) ? 2 : 13;
                    int n = (bi == 0) ? 15 : (bi == 1) ? r + 1 : r + 5;
                    do_cfg((pi == 0) ? 3 : 9, n, r, b, 1'b1, "R3");
                    fill(pi * 40 + r * 5 + bi);
                    run_block(bi == 1, 1'b0, 1'b0, "R2");
                end
            end
        end

        // R4: rejected settings keep prior code
        do_cfg(3, 15, 3, 4, 1'b1, "R4");
        do_cfg(9, 15, 0, 1, 1'b0, "R4");
        do_cfg(9, 15, 7, 1, 1'b0, "R4");
        do_cfg(9, 4, 4, 1, 1'b0, "R4");
        fill(77);
        run_block(1'b0, 1'b0, 1'b0, "R4");
        do_cfg(3, 12, 5, 2, 1'b1, "R4");

        // R8: strobe in mid block has no effect
        fill(11);
        run_block(1'b1, 1'b0, 1'b1, "R8");
        chk(cfg_err == 1'b0 && busy == 1'b0, "R8", "err/busy after mid-block strobe",
            int'(cfg_err) * 2 + int'(busy), 0);
        fill(12);
        run_block(1'b0, 1'b0, 1'b0, "R8");

        // R9: config and start symbol in the same idle cycle
        fill(21);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_poly = BW'(9); cfg_len = BW'(13);
        cfg_nchk = RWB'(6); cfg_root = BW'(3);
        in_valid = 1'b1; in_sob = 1'b1; in_data = BW'(dat[0]); out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R9", "symbol held while config taken",
            int'(in_ready) * 2 + int'(out_valid), 0);
        @(negedge clk);
        cfg_valid = 1'b0;
        #1;
        chk(busy == 1'b1, "R9", "rebuild started", int'(busy), 1);
        cur_poly = 9; cur_n = 13; cur_r = 6; cur_b = 3;
        run_block(1'b0, 1'b0, 1'b0, "R9");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule